// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets software reach the eight one-byte internal registers of a two-wire serial controller through a single 64-bit command word. Software writes the whole word at once. The word carries a busy/valid flag, a direction flag, an operation code, a three-bit register index and a 32-bit data field. When the operation code selects the register path, the bridge performs one access on a simple internal register port. It then drops the valid flag. For a read, it also returns the fetched byte in the low data bits.

Software starts an access by writing a word with the valid flag set, then polls the word until the flag reads back as zero. The internal register space holds the following indices, which the controller behind the port decodes:
- 0: own address
- 1: data
- 2: control
- 3: clock setup when written, state code when read
- 4: extended own address
- 7: soft reset

Bus signalling and clock generation sit behind the port and are not part of this block.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the command word reads as all zeros and neither port strobe is asserted.
- R2: When no access is pending, a write of the command word is stored whole and reads back unchanged in the following cycle.
- R3: A stored word with valid (bit 63) set and operation code (bits 60:57) equal to 6 raises exactly one strobe for one cycle, in the cycle right after the store. The strobe carries register index bits 34:32 on `regSel`. If the read flag (bit 56) is clear, the strobe is `regWrEn` and bits 7:0 appear on `regWrData`.
- R4: For such a word with the read flag set, the strobe is `regRdEn` instead. The byte the port returns on `regRdData` one cycle after the strobe becomes bits 7:0 of the command word, and bits 31:8 become zero.
- R5: A register-path access clears the valid flag exactly two cycles after the store. The flag still reads as one one cycle after the store.
- R6: On completion of a register-path write, every bit of the word except the valid flag keeps its stored value.
- R7: A valid word with any other operation code clears the valid flag one cycle after the store. It zeroes bits 31:0, keeps bits 62:32, and raises no strobe.
- R8: A command write that arrives while the valid flag is set is ignored. The pending access completes as if it had not happened.
- R9: A word stored with the valid flag clear is kept as written, starts no access and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Software write of the command word |
| cmdWrData | input | 64 | Command word to write |
| cmdRdData | output | 64 | Current command word, for polling |
| regSel | output | 3 | Internal register index |
| regWrEn | output | 1 | Internal register write strobe |
| regWrData | output | 8 | Byte to write |
| regRdEn | output | 1 | Internal register read strobe |
| regRdData | input | 8 | Byte returned one cycle after `regRdEn` |

## Verification
Every result has a fixed distance from the clock edge that stores the command word:
- the stored word reads back one cycle later;
- the port strobe is valid during the first cycle after the store and gone by the second;
- a non-register operation completes after one cycle;
- a register access completes, with read data in place, after two cycles.

The bench drives on falling edges and samples on the falling edge after each of those counts of rising edges. It checks the word and the strobes at each of these points, so a result that arrives a cycle early or late is caught. Ignored writes are issued during both busy cycles, and the final word is compared afterwards.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int WORD_W    = 64;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 3;
  localparam int OP_W      = 4;
  localparam int FIELD_W   = 32;
  localparam int VALID_BIT = 63;
  localparam int READ_BIT  = 56;
  localparam int OP_LSB    = 57;
  localparam int IDX_LSB   = 32;
  localparam logic [OP_W-1:0] ACCESS_OP = 4'd6;

  typedef struct packed {
    logic load;
    logic issue;
    logic capture;
    logic finishNop;
  } ctrlStrobes_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrEn,
  input  logic         pendingIn,
  input  logic         opAccessIn,
  output ctrlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_CAPT} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes  = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (pendingIn) begin
          if (opAccessIn) begin
            strobes.issue = 1'b1;
            stateNxt      = ST_CAPT;
          end else begin
            strobes.finishNop = 1'b1;
          end
        end else if (cmdWrEn) begin
          strobes.load = 1'b1;
        end
      end
      ST_CAPT: begin
        strobes.capture = 1'b1;
        stateNxt        = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [WORD_W-1:0] cmdWord,
  output logic              pending,
  output logic              opAccess,
  output logic [IDX_W-1:0]  regSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);
  localparam int PAD_W = FIELD_W - DATA_W;
  logic isRead;

  assign pending   = cmdWord[VALID_BIT];
  assign isRead    = cmdWord[READ_BIT];
  assign opAccess  = (cmdWord[OP_LSB +: OP_W] == ACCESS_OP);
  assign regSel    = cmdWord[IDX_LSB +: IDX_W];
  assign regWrData = cmdWord[DATA_W-1:0];
  assign regWrEn   = strobes.issue & ~isRead;
  assign regRdEn   = strobes.issue & isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0;
    end else if (strobes.load) begin
      cmdWord <= cmdWrData;
    end else if (strobes.finishNop) begin
      cmdWord[VALID_BIT]     <= 1'b0;
      cmdWord[FIELD_W-1:0]   <= '0;
    end else if (strobes.capture) begin
      cmdWord[VALID_BIT] <= 1'b0;
      if (isRead) cmdWord[FIELD_W-1:0] <= {{PAD_W{1'b0}}, regRdData};
    end
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [WORD_W-1:0] cmdWrData,
  output logic [WORD_W-1:0] cmdRdData,
  output logic [IDX_W-1:0]  regSel,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);
  ctrlStrobes_t strobes;
  logic pending, opAccess;

  bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .pendingIn(pending), .opAccessIn(opAccess), .strobes(strobes)
  );

  bridge_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdWrData(cmdWrData),
    .regRdData(regRdData), .cmdWord(cmdRdData), .pending(pending),
    .opAccess(opAccess), .regSel(regSel), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk
  import bridge_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] cmdRdData,
  input logic              regWrEn,
  input logic              regRdEn
);
  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));
  // R3
  strobe_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> (cmdRdData[VALID_BIT] && cmdRdData[OP_LSB +: OP_W] == ACCESS_OP));
  // R4
  single_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);
  // R5
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |=> cmdRdData[VALID_BIT] ##1 !cmdRdData[VALID_BIT]);
  // R7
  nop_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdData[VALID_BIT] && cmdRdData[OP_LSB +: OP_W] != ACCESS_OP)
      |=> (!cmdRdData[VALID_BIT] && cmdRdData[FIELD_W-1:0] == '0));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRdData[VALID_BIT] |=> cmdRdData[62:FIELD_W] == $past(cmdRdData[62:FIELD_W]));
endmodule

bind ind_reg_bridge bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdRdData(cmdRdData),
  .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [63:0] cmdWrData = '0;
  logic [63:0] cmdRdData;
  logic [2:0]  regSel;
  logic        regWrEn, regRdEn;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData = '0;

  logic [7:0] modelMem [8];
  logic [7:0] shadow   [8];
  localparam logic [7:0] STATE_CODE = 8'hA5;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ind_reg_bridge u_dut (.*);

  // internal register port model: read data one cycle after strobe
  always @(posedge clk) begin
    if (regWrEn) modelMem[regSel] <= regWrData;
    if (regRdEn) regRdData <= (regSel == 3'd3) ? STATE_CODE : modelMem[regSel];
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkWord(logic v, logic [3:0] op, logic rd,
                                         logic [2:0] idx, logic [31:0] d);
    logic [63:0] w = '0;
    w[63] = v; w[60:57] = op; w[56] = rd; w[34:32] = idx; w[31:0] = d;
    return w;
  endfunction

  // store at next rising edge, with optional busy writes during the two cycles after
  task automatic access(logic [63:0] w, bit busyPoke);
    logic [63:0] expEnd;
    logic isAcc = w[63] && (w[60:57] == 4'd6);
    logic rd = w[56];
    int idx = int'(w[34:32]);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = w;
    @(negedge clk); cmdWrEn = 1'b0;
    chk("R2 readback", cmdRdData, w);
    chk(isAcc ? "R3 wr strobe" : "R7/R9 no wr strobe", {63'd0, regWrEn}, {63'd0, isAcc && !rd});
    chk(isAcc ? "R4 rd strobe" : "R7/R9 no rd strobe", {63'd0, regRdEn}, {63'd0, isAcc && rd});
    if (isAcc) begin
      chk("R3 sel", {61'd0, regSel}, {61'd0, w[34:32]});
      if (!rd) chk("R3 wdata", {56'd0, regWrData}, {56'd0, w[7:0]});
    end
    if (busyPoke) begin cmdWrEn = 1'b1; cmdWrData = ~w; end
    @(negedge clk);
    if (isAcc) begin
      chk("R5 valid held", {63'd0, cmdRdData[63]}, 64'd1);
      chk("R3 strobes gone", {62'd0, regWrEn, regRdEn}, 64'd0);
      if (busyPoke) cmdWrData = 64'h8C00_0000_0000_0011;
      @(negedge clk);
      cmdWrEn = 1'b0;
      if (rd) expEnd = {1'b0, w[62:32], 24'd0, (idx == 3) ? STATE_CODE : shadow[idx]};
      else begin expEnd = {1'b0, w[62:0]}; shadow[idx] = w[7:0]; end
      chk(rd ? "R4/R5 read result" : "R5/R6 write result", cmdRdData, expEnd);
    end else begin
      cmdWrEn = 1'b0;
      expEnd = w[63] ? {1'b0, w[62:32], 32'd0} : w;
      chk(w[63] ? "R7 nop result" : "R9 kept", cmdRdData, expEnd);
      chk("R7/R9 no strobe", {62'd0, regWrEn, regRdEn}, 64'd0);
    end
    if (busyPoke) chk("R8 ignored", cmdRdData, expEnd);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      modelMem[i] = 8'(i * 17 + 3);
      shadow[i]   = 8'(i * 17 + 3);
    end
    #1;
    chk("R1 reset word", cmdRdData, 64'd0);
    chk("R1 reset strobes", {62'd0, regWrEn, regRdEn}, 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 after release", cmdRdData, 64'd0);
    // reads of initial contents
    for (int i = 0; i < 8; i++)
      access(mkWord(1'b1, 4'd6, 1'b1, 3'(i), 32'hDEAD_BE00), 1'b0);
    // writes of computed values, then read back
    for (int i = 0; i < 8; i++)
      access(mkWord(1'b1, 4'd6, 1'b0, 3'(i), 32'h1234_5600 | 32'(8'(i * 29 + 64))), i[0]);
    for (int i = 0; i < 8; i++)
      access(mkWord(1'b1, 4'd6, 1'b1, 3'(i), 32'hFFFF_FFFF), i[0]);
    // other operation codes
    for (int op = 0; op < 16; op++)
      if (op != 6) access(mkWord(1'b1, 4'(op), op[0], 3'(op), 32'hCAFE_0000 | 32'(op)), op == 3);
    // valid clear: stored, no access
    access(mkWord(1'b0, 4'd6, 1'b0, 3'd2, 32'h0000_00AB), 1'b0);
    access(mkWord(1'b1, 4'd6, 1'b1, 3'd2, 32'd0), 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule